// File: doc/BRIEF.md
# Control-Word Register Datapath

A single-cycle datapath. One 16-bit control word, held for one clock cycle, sets every choice the datapath makes. Its fields select:

- two read registers and one write register in an eight-entry register file;
- the source of Bus B, either register data or an external constant;
- the operation of a function unit that does arithmetic, logic and shifts;
- the source of Bus D, either the function-unit result or external input data;
- whether Bus D is written back on the next rising clock edge.

Bus A is driven out as an address port and Bus B as a data port. With the write strobe low, a control word can therefore set up a memory or output transfer without changing any register.

The function unit raises four status flags from its result: overflow, carry, negative and zero. A sequencer steps the datapath by supplying one control word per cycle. A transfer such as R0 <= R1 + R2 completes in a single clock.

Top module: `ctrl_word_datapath`

## Requirements
- R1: The control word fields are dst=[15:13], src_a=[12:10], src_b=[9:7], b_sel=[6], func=[5:2], d_sel=[1], wr_en=[0]. `addr_o` shows the register selected by src_a combinationally.
- R2: With b_sel=0, Bus B carries the register selected by src_b; with b_sel=1 it carries `const_i`. `data_o` always equals Bus B.
- R3: With d_sel=0, Bus D carries the function-unit result; with d_sel=1 it carries `data_in_i`.
- R4: With wr_en=1, the register selected by dst loads Bus D on the rising clock edge, so R0 <= R1 + R2 takes one cycle.
- R5: With wr_en=0, no register changes, whatever the other fields hold.
- R6: In a cycle that writes a register and also reads it, the read returns the old value; the new value appears after the edge.
- R7: Arithmetic codes (func[3]=0) compute F = A + Y + func[0], where Y is 0, B, ~B or all ones for func[2:1] = 00, 01, 10, 11. This gives transfer A, A+1, A+B, A+B+1, A+~B, A-B, A-1, and transfer A for codes 0..7.
- R8: Other function codes:

  | func | Result |
  |------|--------|
  | 1000 | A AND B |
  | 1001 | A OR B |
  | 1010 | A XOR B |
  | 1011 | NOT A |
  | 1100 | B |
  | 1101 | B shifted right one place, zero filled |
  | 1110 | B shifted left one place, zero filled |
  | 1111 | zero |

- R9: N is the result MSB and Z is set when the result is zero. For arithmetic codes, C is the adder carry-out and V is two's-complement overflow of A + Y. For codes with func[3]=1, C and V are 0. All four flags are combinational.
- R10: An active-low asynchronous reset clears all eight registers to zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ctrl_word_i | input | 16 | Control word for the current cycle |
| const_i | input | DATA_W | Constant selectable onto Bus B |
| data_in_i | input | DATA_W | External data selectable onto Bus D |
| addr_o | output | DATA_W | Bus A |
| data_o | output | DATA_W | Bus B |
| flag_v_o | output | 1 | Overflow flag |
| flag_c_o | output | 1 | Carry flag |
| flag_n_o | output | 1 | Negative flag |
| flag_z_o | output | 1 | Zero flag |

## Verification
The buses and flags are combinational, so the bench drives each control word on the falling edge and compares them one nanosecond later, within the same cycle. A register write is due one rising edge after its control word. Each write is therefore confirmed on the following cycle by selecting that register onto Bus A. This also makes the same-cycle read-during-write check observe the old contents before the edge. Reset clearing is asynchronous and is checked while reset is still held, with no clock edge needed.

// File: rtl/dp_pkg.sv
package dp_pkg;
  localparam int CW_W   = 16;
  localparam int REG_AW = 3;

  typedef struct packed {
    logic [REG_AW-1:0] dst;
    logic [REG_AW-1:0] src_a;
    logic [REG_AW-1:0] src_b;
    logic              b_sel;
    logic [3:0]        func;
    logic              d_sel;
    logic              wr_en;
  } ctrl_word_t;

  typedef enum logic [3:0] {
    FN_MOV_A  = 4'h0, FN_INC   = 4'h1, FN_ADD   = 4'h2, FN_ADD_C = 4'h3,
    FN_ADD_NB = 4'h4, FN_SUB   = 4'h5, FN_DEC   = 4'h6, FN_MOV_A2 = 4'h7,
    FN_AND    = 4'h8, FN_OR    = 4'h9, FN_XOR   = 4'hA, FN_NOT   = 4'hB,
    FN_PASS_B = 4'hC, FN_SHR   = 4'hD, FN_SHL   = 4'hE, FN_ZERO  = 4'hF
  } func_e;
endpackage

// File: rtl/dp_regfile.sv
module dp_regfile #(
  parameter int DATA_W = 8,
  parameter int AW     = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [AW-1:0]     waddr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [AW-1:0]     raddr_a_i,
  input  logic [AW-1:0]     raddr_b_i,
  output logic [DATA_W-1:0] rdata_a_o,
  output logic [DATA_W-1:0] rdata_b_o
);
  localparam int NREG = 1 << AW;

  logic [DATA_W-1:0] regs_q [NREG];

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    logic load;
    assign load = we_i && (waddr_i == AW'(g));
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)   regs_q[g] <= '0;
      else if (load) regs_q[g] <= wdata_i;
    end
  end

  // reads see pre-edge contents
  assign rdata_a_o = regs_q[raddr_a_i];
  assign rdata_b_o = regs_q[raddr_b_i];
endmodule

// File: rtl/dp_arith.sv
module dp_arith #(
  parameter int DATA_W = 8
) (
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  input  logic [1:0]        y_sel_i,
  input  logic              cin_i,
  output logic [DATA_W-1:0] g_o,
  output logic              c_o,
  output logic              v_o
);
  logic [DATA_W-1:0] y;
  logic [DATA_W:0]   sum;

  always_comb begin
    unique case (y_sel_i)
      2'b00:   y = '0;
      2'b01:   y = b_i;
      2'b10:   y = ~b_i;
      default: y = '1;
    endcase
  end

  assign sum = {1'b0, a_i} + {1'b0, y} + {{DATA_W{1'b0}}, cin_i};
  assign g_o = sum[DATA_W-1:0];
  assign c_o = sum[DATA_W];
  assign v_o = (a_i[DATA_W-1] == y[DATA_W-1]) && (sum[DATA_W-1] != a_i[DATA_W-1]);
endmodule

// File: rtl/dp_logic_shift.sv
module dp_logic_shift #(
  parameter int DATA_W = 8
) (
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  input  logic [2:0]        sel_i,
  output logic [DATA_W-1:0] h_o
);
  logic [DATA_W-1:0] shr, shl;

  assign shr = {1'b0, b_i[DATA_W-1:1]};
  assign shl = {b_i[DATA_W-2:0], 1'b0};

  always_comb begin
    unique case (sel_i)
      3'd0:    h_o = a_i & b_i;
      3'd1:    h_o = a_i | b_i;
      3'd2:    h_o = a_i ^ b_i;
      3'd3:    h_o = ~a_i;
      3'd4:    h_o = b_i;
      3'd5:    h_o = shr;
      3'd6:    h_o = shl;
      default: h_o = '0;
    endcase
  end
endmodule

// File: rtl/dp_func_unit.sv
module dp_func_unit #(
  parameter int DATA_W = 8
) (
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  input  logic [3:0]        func_i,
  output logic [DATA_W-1:0] f_o,
  output logic              v_o,
  output logic              c_o,
  output logic              n_o,
  output logic              z_o
);
  logic [DATA_W-1:0] g, h;
  logic              g_c, g_v;

  dp_arith #(.DATA_W(DATA_W)) arith_i (
    .a_i(a_i), .b_i(b_i), .y_sel_i(func_i[2:1]), .cin_i(func_i[0]),
    .g_o(g), .c_o(g_c), .v_o(g_v)
  );

  dp_logic_shift #(.DATA_W(DATA_W)) lsh_i (
    .a_i(a_i), .b_i(b_i), .sel_i(func_i[2:0]), .h_o(h)
  );

  assign f_o = func_i[3] ? h : g;
  assign c_o = !func_i[3] && g_c;
  assign v_o = !func_i[3] && g_v;
  assign n_o = f_o[DATA_W-1];
  assign z_o = (f_o == '0);
endmodule

// File: rtl/ctrl_word_datapath.sv
module ctrl_word_datapath
  import dp_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [CW_W-1:0]   ctrl_word_i,
  input  logic [DATA_W-1:0] const_i,
  input  logic [DATA_W-1:0] data_in_i,
  output logic [DATA_W-1:0] addr_o,
  output logic [DATA_W-1:0] data_o,
  output logic              flag_v_o,
  output logic              flag_c_o,
  output logic              flag_n_o,
  output logic              flag_z_o
);
  ctrl_word_t        cw;
  logic [DATA_W-1:0] bus_a, reg_b, bus_b, bus_d, fu_out;

  assign cw = ctrl_word_t'(ctrl_word_i);

  dp_regfile #(.DATA_W(DATA_W), .AW(REG_AW)) rf_i (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .we_i(cw.wr_en), .waddr_i(cw.dst), .wdata_i(bus_d),
    .raddr_a_i(cw.src_a), .raddr_b_i(cw.src_b),
    .rdata_a_o(bus_a), .rdata_b_o(reg_b)
  );

  assign bus_b = cw.b_sel ? const_i : reg_b;

  dp_func_unit #(.DATA_W(DATA_W)) fu_i (
    .a_i(bus_a), .b_i(bus_b), .func_i(cw.func), .f_o(fu_out),
    .v_o(flag_v_o), .c_o(flag_c_o), .n_o(flag_n_o), .z_o(flag_z_o)
  );

  assign bus_d  = cw.d_sel ? data_in_i : fu_out;
  assign addr_o = bus_a;
  assign data_o = bus_b;
endmodule

// File: rtl/dp_datapath_chk.sv
module dp_datapath_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [15:0]       ctrl_word_i,
  input logic [DATA_W-1:0] const_i,
  input logic [DATA_W-1:0] data_in_i,
  input logic [DATA_W-1:0] addr_o,
  input logic [DATA_W-1:0] data_o,
  input logic              flag_v_o,
  input logic              flag_c_o,
  input logic              flag_n_o,
  input logic              flag_z_o,
  input logic [DATA_W-1:0] bus_d_i
);
  logic [2:0] dst, src_a;
  assign dst   = ctrl_word_i[15:13];
  assign src_a = ctrl_word_i[12:10];

  // R4
  write_lands_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_word_i[0] |=> (src_a != $past(dst)) || (addr_o == $past(bus_d_i)));

  // R3
  ext_data_lands_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_word_i[0] && ctrl_word_i[1]) |=> (src_a != $past(dst)) || (addr_o == $past(data_in_i)));

  // R5
  no_write_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ctrl_word_i[0] |=> (src_a != $past(src_a)) || (addr_o == $past(addr_o)));

  // R2
  const_on_bus_b_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_word_i[6] |-> data_o == const_i);

  // R9
  logic_no_cv_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_word_i[5] |-> !flag_c_o && !flag_v_o);

  // R9
  zero_not_neg_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flag_z_o |-> !flag_n_o);
endmodule

bind ctrl_word_datapath dp_datapath_chk #(.DATA_W(DATA_W)) chk_i (
  .clk_i(clk_i), .rst_ni(rst_ni), .ctrl_word_i(ctrl_word_i),
  .const_i(const_i), .data_in_i(data_in_i), .addr_o(addr_o), .data_o(data_o),
  .flag_v_o(flag_v_o), .flag_c_o(flag_c_o), .flag_n_o(flag_n_o),
  .flag_z_o(flag_z_o), .bus_d_i(bus_d)
);

// File: tb/ctrl_word_datapath_tb_top.sv
`timescale 1ns/1ps
module ctrl_word_datapath_tb_top;
  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [15:0]  cw_in = '0;
  logic [W-1:0] k_in = '0, din = '0;
  logic [W-1:0] addr, data;
  logic         fv, fc, fn, fz;

  int n_chk = 0, n_fail = 0;
  logic [W-1:0] mdl [8];

  always #2.5 clk = ~clk;

  ctrl_word_datapath #(.DATA_W(W)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .ctrl_word_i(cw_in), .const_i(k_in),
    .data_in_i(din), .addr_o(addr), .data_o(data),
    .flag_v_o(fv), .flag_c_o(fc), .flag_n_o(fn), .flag_z_o(fz)
  );

  function automatic logic [15:0] mk(input int da, aa, ba, mb, fs, md, rw);
    return {da[2:0], aa[2:0], ba[2:0], mb[0], fs[3:0], md[0], rw[0]};
  endfunction

  // returns {v, c, f}
  function automatic logic [W+1:0] ref_fu(input logic [3:0] fs, input logic [W-1:0] a, b);
    logic [W-1:0] y, f;
    logic [W:0]   s;
    logic         c, v;
    c = 1'b0; v = 1'b0;
    if (!fs[3]) begin
      case (fs[2:1])
        2'b00: y = '0;
        2'b01: y = b;
        2'b10: y = ~b;
        default: y = '1;
      endcase
      s = {1'b0, a} + {1'b0, y} + (W+1)'(fs[0]);
      f = s[W-1:0]; c = s[W];
      v = (a[W-1] == y[W-1]) && (f[W-1] != a[W-1]);
    end else begin
      case (fs[2:0])
        3'd0: f = a & b;
        3'd1: f = a | b;
        3'd2: f = a ^ b;
        3'd3: f = ~a;
        3'd4: f = b;
        3'd5: f = b >> 1;
        3'd6: f = b << 1;
        default: f = '0;
      endcase
    end
    return {v, c, f};
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act, exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // drive one control word for one cycle, check combinational outputs, update model
  task automatic apply(input logic [15:0] c, input logic [W-1:0] k, d);
    logic [W-1:0] ea, eb;
    logic [W+1:0] r;
    @(negedge clk);
    cw_in = c; k_in = k; din = d;
    #1;
    ea = mdl[c[12:10]];
    eb = c[6] ? k : mdl[c[9:7]];
    r  = ref_fu(c[5:2], ea, eb);
    check(addr == ea, "R1 addr", 32'(addr), 32'(ea));
    check(data == eb, "R2 data", 32'(data), 32'(eb));
    check({fv, fc, fn, fz} == {r[W+1], r[W], r[W-1], r[W-1:0] == '0},
          "R9 flags", {28'd0, fv, fc, fn, fz},
          {28'd0, r[W+1], r[W], r[W-1], r[W-1:0] == '0});
    @(posedge clk);
    if (c[0]) mdl[c[15:13]] = c[1] ? d : r[W-1:0];
  endtask

  task automatic reset_sweep();
    for (int i = 0; i < 8; i++) begin
      cw_in = mk(0, i, 0, 0, 0, 0, 0);
      #1;
      check(addr == '0, "R10 reset", 32'(addr), 32'd0);
    end
    for (int i = 0; i < 8; i++) mdl[i] = '0;
  endtask

  initial begin
    #(5.0 * 200000);
    n_chk++; n_fail++;
    $display("FAIL R4 watchdog actual=timeout expected=finish");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic [W-1:0] old3;
    logic [W+1:0] r;
    void'($urandom(32'h1f2e3d4c));
    for (int i = 0; i < 8; i++) mdl[i] = '0;
    #1;
    reset_sweep();
    repeat (2) @(negedge clk);
    rst_n = 1'b1;

    // R3: load registers from external data
    apply(mk(1, 0, 0, 0, 0, 1, 1), 8'h00, 8'h47);
    apply(mk(2, 1, 0, 0, 0, 1, 1), 8'h00, 8'h2C);
    apply(mk(0, 2, 0, 0, 0, 0, 0), 8'h00, 8'h00);
    check(addr == 8'h2C, "R3 d_sel ext", 32'(addr), 32'h2C);

    // R4: R0 <= R1 + R2 in one cycle
    apply(mk(0, 1, 2, 0, 2, 0, 1), 8'h00, 8'hEE);
    apply(mk(4, 0, 0, 0, 0, 0, 0), 8'h00, 8'h00);
    check(addr == 8'h73, "R4 R0<=R1+R2", 32'(addr), 32'h73);

    // R6: same-cycle write/read of R3 shows old value
    apply(mk(3, 0, 0, 0, 0, 1, 1), 8'h00, 8'h11);
    @(negedge clk);
    cw_in = mk(3, 3, 0, 0, 0, 1, 1); din = 8'h5A;
    #1;
    old3 = addr;
    check(old3 == 8'h11, "R6 old value", 32'(old3), 32'h11);
    @(posedge clk); mdl[3] = 8'h5A;
    apply(mk(0, 3, 0, 0, 0, 0, 0), 8'h00, 8'h00);
    check(addr == 8'h5A, "R6 new value", 32'(addr), 32'h5A);

    // R5: wr_en=0 with every other field active
    apply(mk(0, 0, 0, 1, 15, 1, 0), 8'hAB, 8'hFF);
    apply(mk(0, 0, 0, 0, 0, 0, 0), 8'h00, 8'h00);
    check(addr == 8'h73, "R5 no write", 32'(addr), 32'h73);

    // R2: constant on Bus B
    apply(mk(0, 0, 1, 1, 0, 0, 0), 8'hC3, 8'h00);
    check(data == 8'hC3, "R2 const", 32'(data), 32'hC3);

    // R7/R8: every function code, operand pairs with overflow and carry
    for (int p = 0; p < 3; p++) begin
      logic [W-1:0] av, bv;
      av = (p == 0) ? 8'h7F : (p == 1) ? 8'hFF : 8'h96;
      bv = (p == 0) ? 8'h01 : (p == 1) ? 8'h01 : 8'h3B;
      apply(mk(1, 0, 0, 0, 0, 1, 1), 8'h00, av);
      apply(mk(2, 0, 0, 0, 0, 1, 1), 8'h00, bv);
      for (int f = 0; f < 16; f++) begin
        r = ref_fu(4'(f), av, bv);
        apply(mk(3, 1, 2, 0, f, 0, 1), 8'h00, 8'h00);
        apply(mk(0, 3, 0, 0, 0, 0, 0), 8'h00, 8'h00);
        if (f < 8) check(addr == r[W-1:0], "R7 arith", 32'(addr), 32'(r[W-1:0]));
        else       check(addr == r[W-1:0], "R8 logic/shift", 32'(addr), 32'(r[W-1:0]));
      end
    end
    // R9: 0x7F + 1 overflows, 0xFF + 1 carries and gives zero
    apply(mk(1, 0, 0, 0, 0, 1, 1), 8'h00, 8'h7F);
    apply(mk(0, 1, 0, 1, 2, 0, 0), 8'h01, 8'h00);
    check({fv, fc, fn, fz} == 4'b1010, "R9 overflow", {28'd0, fv, fc, fn, fz}, 32'hA);
    apply(mk(1, 0, 0, 0, 0, 1, 1), 8'h00, 8'hFF);
    apply(mk(0, 1, 0, 1, 2, 0, 0), 8'h01, 8'h00);
    check({fv, fc, fn, fz} == 4'b0101, "R9 carry zero", {28'd0, fv, fc, fn, fz}, 32'h5);

    // random control words
    for (int i = 0; i < 600; i++)
      apply(16'($urandom()), W'($urandom()), W'($urandom()));

    // R10: asynchronous reset mid-run
    @(negedge clk);
    rst_n = 1'b0;
    reset_sweep();
    @(negedge clk);
    rst_n = 1'b1;
    apply(mk(0, 5, 6, 0, 0, 0, 0), 8'h00, 8'h00);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule